// File: doc/BRIEF.md
# Job Slot Interrupt Controller

This block sits between a 32-bit register port and sixteen job slots. Each slot signals a job that has finished or failed with a one-cycle pulse. The block latches these pulses into a raw interrupt word. Finished jobs go to the low half and failed jobs to the high half. The raw word is ANDed with a software mask, and a single interrupt line goes high whenever the masked result is non-zero.

The block also keeps a snapshot of slot activity. For each slot it records whether a job is running and whether a further job is queued behind it. The snapshot is not tracked continuously. It is refreshed only when software writes the interrupt-acknowledge register, and only for the slots that the written word names. Software acknowledges a slot's interrupt and, in the same write, gets a current view of that slot.

Register addresses at or above a slot-window base are not decoded here. They are passed to a per-slot sub-interface as a slot number and an in-slot offset. Read data for those addresses comes back from that interface.

Top module: `jsic_top`

## Requirements
- R1: After reset the raw word, the mask, the masked word and the slot snapshot all read 0, and `irq_o` is low.
- R2: A pulse on `done_i[n]` sets raw bit n. The bit stays set until it is acknowledged.
- R3: A pulse on `fail_i[n]` sets raw bit 16+n. The bit stays set until it is acknowledged.
- R4: The mask register (offset 0x08) is read/write. The masked word (offset 0x0C) reads as raw AND mask. `irq_o` is high exactly when the masked word is non-zero.
- R5: A write to the acknowledge register (offset 0x04) clears every raw bit that is 1 in the written value and leaves the other raw bits unchanged. The acknowledge register reads as 0.
- R6: An acknowledge write also refreshes the slot snapshot (offset 0x10). Let S be the written value's bits 15:0 ORed with its bits 31:16. For every slot n in S, snapshot bit n takes `active_i[n]` and snapshot bit 16+n takes `next_i[n]`, both sampled in the cycle of the write. Snapshot bits of slots outside S keep their values, and the snapshot changes at no other time.
- R7: If a done or fail pulse arrives in the same cycle as an acknowledge write to the same raw bit, the bit ends up set.
- R8: A request at or above the window base (default 0x800) drives `slot_sel_o`. The slot number is bits 10:7 of (address − base) and the offset is bits 6:0. Such a request changes no interrupt register, and a read returns `slot_rdata_i`.
- R9: Writes to the raw word (0x00), the masked word (0x0C) and the snapshot (0x10) have no effect.
- R10: A read issued in cycle t shows `rd_valid_o` high with its data in cycle t+1. Unmapped addresses below the window base read 0 and do not drive `slot_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | 32 | Read data |
| slot_sel_o | output | 1 | Request targets the slot window |
| slot_we_o | output | 1 | Slot-window request is a write |
| slot_idx_o | output | 4 | Slot number |
| slot_off_o | output | 7 | Offset inside the slot's window |
| slot_wdata_o | output | 32 | Write data to the slot |
| slot_rdata_i | input | 32 | Read data from the addressed slot |
| done_i | input | 16 | Per-slot job-finished pulses |
| fail_i | input | 16 | Per-slot job-failed pulses |
| active_i | input | 16 | Per-slot job-running level |
| next_i | input | 16 | Per-slot job-queued level |
| irq_o | output | 1 | Interrupt line |

## Verification
Four behaviours are checked by assertions on every cycle:
- every pulse lands in its raw bit one cycle later, which covers the event-wins rule;
- acknowledged bits without a coinciding event clear;
- snapshot bits outside the acknowledged set never move, and bits inside it take the sampled levels;
- a window access or a write to a read-only register leaves the mask and raw word untouched.

The bench scenarios are needed for the rest. They cover the way the low and high halves of an acknowledge fold together into one slot set, the address arithmetic that produces slot number and offset, read data returned from the slot side, the read latency, and the interrupt line following particular mask settings.

// File: rtl/jsic_pkg.sv
package jsic_pkg;
  localparam int NSLOT = 16;
  localparam int DW    = 32;
  localparam int IDX_W = $clog2(NSLOT);

  localparam logic [7:0] OFF_RAW   = 8'h00;
  localparam logic [7:0] OFF_ACK   = 8'h04;
  localparam logic [7:0] OFF_MASK  = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h0C;
  localparam logic [7:0] OFF_STATE = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_ACK,
    SEL_MASK,
    SEL_STAT,
    SEL_STATE
  } reg_sel_e;
endpackage

// File: rtl/jsic_addr_decode.sv
module jsic_addr_decode
  import jsic_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h800,
  parameter int              SPAN_LG  = 7
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               in_win_o,
  output reg_sel_e           sel_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [SPAN_LG-1:0] off_o
);
  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel      = addr_i - WIN_BASE;
    in_win_o = (addr_i >= WIN_BASE);
    idx_o    = IDX_W'(rel >> SPAN_LG);
    off_o    = rel[SPAN_LG-1:0];
    sel_o    = SEL_NONE;
    if (!in_win_o) begin
      if      (addr_i == ADDR_W'(OFF_RAW))   sel_o = SEL_RAW;
      else if (addr_i == ADDR_W'(OFF_ACK))   sel_o = SEL_ACK;
      else if (addr_i == ADDR_W'(OFF_MASK))  sel_o = SEL_MASK;
      else if (addr_i == ADDR_W'(OFF_STAT))  sel_o = SEL_STAT;
      else if (addr_i == ADDR_W'(OFF_STATE)) sel_o = SEL_STATE;
      else                                   sel_o = SEL_NONE;
    end
  end
endmodule

// File: rtl/jsic_irq_core.sv
module jsic_irq_core
  import jsic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] done_i,
  input  logic [NSLOT-1:0] fail_i,
  input  logic             ack_en_i,
  input  logic [DW-1:0]    ack_val_i,
  input  logic             mask_we_i,
  input  logic [DW-1:0]    mask_wdata_i,
  output logic [DW-1:0]    raw_o,
  output logic [DW-1:0]    mask_o,
  output logic [DW-1:0]    stat_o,
  output logic             irq_o
);
  logic [DW-1:0] raw_q, raw_d, mask_q, mask_d, ev_vec, ack_vec;
  logic          raw_en;

  always_comb begin
    ev_vec  = {fail_i, done_i};
    ack_vec = ack_en_i ? ack_val_i : '0;
    raw_en  = ack_en_i || (|ev_vec);
    // a new event overrides a simultaneous acknowledge of the same bit
    raw_d   = (raw_q & ~ack_vec) | ev_vec;
    mask_d  = mask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      if (raw_en)    raw_q  <= raw_d;
      if (mask_we_i) mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign stat_o = raw_q & mask_q;
  assign irq_o  = |stat_o;

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|{fail_i, done_i}) |=> ((raw_q & $past({fail_i, done_i})) == $past({fail_i, done_i})));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en_i |=> ((raw_q & $past(ack_val_i & ~{fail_i, done_i})) == '0));

  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_q == $past(mask_wdata_i)));
endmodule

// File: rtl/jsic_slot_state.sv
module jsic_slot_state
  import jsic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en_i,
  input  logic [NSLOT-1:0] cap_set_i,
  input  logic [NSLOT-1:0] active_i,
  input  logic [NSLOT-1:0] next_i,
  output logic [DW-1:0]    state_o
);
  logic [NSLOT-1:0] run_q, run_d, que_q, que_d;

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    logic take;
    always_comb begin
      take     = cap_en_i && cap_set_i[n];
      run_d[n] = take ? active_i[n] : run_q[n];
      que_d[n] = take ? next_i[n]   : que_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      que_q <= '0;
    end else if (cap_en_i) begin
      run_q <= run_d;
      que_q <= que_d;
    end
  end

  assign state_o = {que_q, run_q};

  assert_hold_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_i |=> (({que_q, run_q} & ~$past({cap_set_i, cap_set_i}))
                 == ($past({que_q, run_q}) & ~$past({cap_set_i, cap_set_i}))));

  assert_capture_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_i |=> (({que_q, run_q} & $past({cap_set_i, cap_set_i}))
                 == ($past({next_i, active_i}) & $past({cap_set_i, cap_set_i}))));

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_i |=> $stable({que_q, run_q}));
endmodule

// File: rtl/jsic_top.sv
module jsic_top
  import jsic_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h800,
  parameter int                SPAN_LG  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  output logic               rd_valid_o,
  output logic [DW-1:0]      rd_data_o,
  output logic               slot_sel_o,
  output logic               slot_we_o,
  output logic [IDX_W-1:0]   slot_idx_o,
  output logic [SPAN_LG-1:0] slot_off_o,
  output logic [DW-1:0]      slot_wdata_o,
  input  logic [DW-1:0]      slot_rdata_i,
  input  logic [NSLOT-1:0]   done_i,
  input  logic [NSLOT-1:0]   fail_i,
  input  logic [NSLOT-1:0]   active_i,
  input  logic [NSLOT-1:0]   next_i,
  output logic               irq_o
);
  logic             in_win, wr_req, rd_req, ack_en, mask_we, rdv_q, rdv_d;
  reg_sel_e         sel;
  logic [DW-1:0]    raw, mask, stat, state, rd_q, rd_d;
  logic [NSLOT-1:0] ack_set;

  jsic_addr_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SPAN_LG(SPAN_LG)) u_dec (
    .addr_i(req_addr_i), .in_win_o(in_win), .sel_o(sel),
    .idx_o(slot_idx_o), .off_o(slot_off_o)
  );

  always_comb begin
    wr_req  = req_valid_i && req_write_i;
    rd_req  = req_valid_i && !req_write_i;
    ack_en  = wr_req && (sel == SEL_ACK);
    mask_we = wr_req && (sel == SEL_MASK);
    ack_set = req_wdata_i[NSLOT-1:0] | req_wdata_i[DW-1:NSLOT];
  end

  jsic_irq_core u_irq (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .fail_i(fail_i),
    .ack_en_i(ack_en), .ack_val_i(req_wdata_i),
    .mask_we_i(mask_we), .mask_wdata_i(req_wdata_i),
    .raw_o(raw), .mask_o(mask), .stat_o(stat), .irq_o(irq_o)
  );

  jsic_slot_state u_state (
    .clk(clk), .rst_n(rst_n), .cap_en_i(ack_en), .cap_set_i(ack_set),
    .active_i(active_i), .next_i(next_i), .state_o(state)
  );

  assign slot_sel_o   = req_valid_i && in_win;
  assign slot_we_o    = slot_sel_o && req_write_i;
  assign slot_wdata_o = req_wdata_i;

  always_comb begin
    rdv_d = rd_req;
    rd_d  = '0;
    if (in_win) rd_d = slot_rdata_i;
    else begin
      case (sel)
        SEL_RAW:   rd_d = raw;
        SEL_MASK:  rd_d = mask;
        SEL_STAT:  rd_d = stat;
        SEL_STATE: rd_d = state;
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      rdv_q <= rdv_d;
      if (rd_req) rd_q <= rd_d;
    end
  end

  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rd_q;

  assert_window_no_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel_o && (fail_i == '0) && (done_i == '0)) |=> ($stable(mask) && $stable(raw)));

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && ((sel == SEL_RAW) || (sel == SEL_STAT) || (sel == SEL_STATE)))
      |=> ($stable(mask) && (($past(raw) & ~raw) == '0)));

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid_o);
endmodule

// File: tb/jsic_top_test.sv
module jsic_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid, slot_sel, slot_we, irq;
  logic [31:0] rd_data, slot_wdata, slot_rdata;
  logic [3:0]  slot_idx;
  logic [6:0]  slot_off;
  logic [15:0] done = '0, fail = '0, active = '0, nxt = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  // slot-side model: echoes the decoded slot and offset
  assign slot_rdata = {16'hBEEF, 5'b0, slot_idx, slot_off};

  jsic_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .slot_sel_o(slot_sel), .slot_we_o(slot_we),
    .slot_idx_o(slot_idx), .slot_off_o(slot_off), .slot_wdata_o(slot_wdata),
    .slot_rdata_i(slot_rdata), .done_i(done), .fail_i(fail), .active_i(active),
    .next_i(nxt), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check("R10 pending reads", 32'(exp_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected read", rd_data, 32'hx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(logic [15:0] d, logic [15:0] f);
    done = d; fail = f;
    @(negedge clk);
    done = '0; fail = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", 32'(irq), 32'd0);
    bus_read(12'h000, 32'h0, "R1 raw");
    bus_read(12'h008, 32'h0, "R1 mask");
    bus_read(12'h00C, 32'h0, "R1 masked");
    bus_read(12'h010, 32'h0, "R1 state");

    pulse(16'h8008, 16'h0000);
    check("R4 irq masked off", 32'(irq), 32'd0);
    bus_read(12'h000, 32'h0000_8008, "R2 done bits");
    pulse(16'h0000, 16'h0081);
    bus_read(12'h000, 32'h0081_8008, "R3 fail bits");

    bus_write(12'h008, 32'h0001_0000);
    check("R4 irq on", 32'(irq), 32'd1);
    bus_read(12'h008, 32'h0001_0000, "R4 mask rd");
    bus_read(12'h00C, 32'h0001_0000, "R4 masked rd");

    // ack slots 0 and 3 (low bit 3, high bit 16)
    active = 16'h000A; nxt = 16'h0008;
    bus_write(12'h004, 32'h0001_0008);
    active = 16'h0000; nxt = 16'h0000;
    bus_read(12'h010, 32'h0008_0008, "R6 snapshot folded");
    bus_read(12'h000, 32'h0080_8000, "R5 ack clear");
    check("R4 irq off", 32'(irq), 32'd0);
    bus_read(12'h004, 32'h0, "R5 ack reads 0");

    active = 16'h0002;
    bus_write(12'h004, 32'h0002_0000);
    active = 16'h0000;
    bus_read(12'h010, 32'h0008_000A, "R6 slot1 only");

    done = 16'h8000;
    bus_write(12'h004, 32'h0000_8000);
    done = '0;
    bus_read(12'h000, 32'h0080_8000, "R7 event wins");
    bus_write(12'h004, 32'h0080_0000);
    bus_read(12'h000, 32'h0000_8000, "R5 clear fail bit");

    bus_write(12'h008, 32'hFFFF_FFFF);
    pulse(16'h0020, 16'h0000);
    check("R4 irq full mask", 32'(irq), 32'd1);

    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'h00C, 32'h0000_0000);
    bus_write(12'h010, 32'hFFFF_FFFF);
    bus_read(12'h000, 32'h0000_8020, "R9 raw ro");
    bus_read(12'h010, 32'h0008_000A, "R9 state ro");
    bus_read(12'h008, 32'hFFFF_FFFF, "R9 mask kept");

    bus_read(12'h994, {16'hBEEF, 5'b0, 4'd3, 7'h14}, "R8 slot read");
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'hF84; req_wdata = 32'h1234_5678;
    #1;
    check("R8 sel", 32'(slot_sel), 32'd1);
    check("R8 we", 32'(slot_we), 32'd1);
    check("R8 idx", 32'(slot_idx), 32'd15);
    check("R8 off", 32'(slot_off), 32'h04);
    check("R8 wdata", slot_wdata, 32'h1234_5678);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    bus_write(12'h808, 32'h0);
    bus_read(12'h008, 32'hFFFF_FFFF, "R8 mask untouched");

    req_valid = 1'b1; req_addr = 12'h040;
    #1;
    check("R10 no sel low", 32'(slot_sel), 32'd0);
    req_valid = 1'b0;
    bus_read(12'h040, 32'h0, "R10 unmapped");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule